// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block translates 32-bit virtual addresses on 4 KB pages through a 64-entry, fully associative table. Every entry carries a 6-bit address-space tag next to its virtual page number. Entries from up to 64 processes can therefore stay resident across a context switch, and no flush is needed. A lookup presents a virtual address and the current address-space tag. One cycle later the block returns a physical address, a hit or fault indication and a cacheable flag. The 12-bit page offset is never translated, so it is returned combinationally in the same cycle. A cache index can start from it while the lookup runs.

The three top address bits select a segment. Two of the segments are kernel physical windows that skip translation: one cached and one uncached. The remaining segments, user space and kernel virtual space, go through the table. When a translated address finds no valid matching entry, the block raises a fault. Software handles the fault and refills an entry through a write port that carries the index, page number, address-space tag, frame number, cacheable bit and valid bit. The block has no hardware table walker.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is 0, so a translated lookup issued right after reset faults.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` high, and 0 otherwise.
- R3: A translated lookup hits when a valid entry has the same 20-bit page number (`lk_vaddr[31:12]`) and the same address-space tag. It then returns `rsp_paddr = {pfn, lk_vaddr[11:0]}`, with `rsp_cacheable` taken from that entry.
- R4: An entry whose address-space tag differs from `lk_asid` never matches, even when its page number is equal.
- R5: A translated lookup with no valid match returns `rsp_fault=1`, `rsp_hit=0`, `rsp_paddr=0` and `rsp_cacheable=0`. An entry written with its valid bit at 0 never matches.
- R6: When `lk_vaddr[31:29]` is 3'b100, translation is bypassed. The response is `rsp_hit=1`, `rsp_fault=0`, `rsp_cacheable=1`, with `rsp_paddr` equal to `lk_vaddr` with bits 31:29 cleared. This holds even when the table is empty.
- R7: When `lk_vaddr[31:29]` is 3'b101, translation is bypassed in the same way, except that `rsp_cacheable=0`.
- R8: When `lk_vaddr[31:29]` is 3'b0xx (user) or 3'b11x (kernel virtual), the address is translated through the table.
- R9: When more than one valid entry matches, the entry with the lowest index supplies the result.
- R10: A write takes effect for lookups that start in the cycle after it. A lookup in the same cycle as a write sees the old contents.
- R11: `lk_offset` equals `lk_vaddr[11:0]` combinationally, in the same cycle.
- R12: `rsp_hit` and `rsp_fault` are never both 1, and both are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address-space tag |
| lk_offset | output | 12 | Untranslated page offset, same cycle |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_asid | input | 6 | Address-space tag for the entry |
| wr_pfn | input | 20 | Physical frame number for the entry |
| wr_cacheable | input | 1 | Cacheable attribute for the entry |
| wr_valid | input | 1 | Valid bit for the entry (0 invalidates) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation succeeded or was bypassed |
| rsp_fault | output | 1 | Translated lookup found no valid entry |
| rsp_cacheable | output | 1 | Cacheable attribute of the result |
| rsp_paddr | output | 32 | Physical address |

## Verification
Two situations are hard to reach from the ports. The first is several entries matching at once, because correct refill software never creates it. The bench builds it on purpose by writing the same page number and tag into a high index and a low index. It then checks that the low index wins, and that the high index takes over once the low one is invalidated. The second is a write and a lookup of the same page landing in the same cycle. The bench drives both on one edge and expects a fault, then repeats the lookup alone and expects a hit.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    // Number of top address bits that select a segment
    localparam int SEG_W = 3;

    typedef enum logic [1:0] {
        SEG_XLATE   = 2'd0,  // translated through the table
        SEG_PHYS_C  = 2'd1,  // kernel physical window, cached
        SEG_PHYS_UC = 2'd2   // kernel physical window, uncached
    } seg_kind_e;

endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import asid_tlb_pkg::*;
(
    input  logic [SEG_W-1:0] top_bits,
    output seg_kind_e        kind
);

    always_comb begin
        unique casez (top_bits)
            3'b0??:  kind = SEG_XLATE;
            3'b100:  kind = SEG_PHYS_C;
            3'b101:  kind = SEG_PHYS_UC;
            default: kind = SEG_XLATE;   // 11x, kernel virtual
        endcase
    end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 6,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [ASID_W-1:0]        wr_asid,
    input  logic [PFN_W-1:0]         wr_pfn,
    input  logic                     wr_cacheable,
    input  logic                     wr_valid,
    input  logic [VPN_W-1:0]         lk_vpn,
    input  logic [ASID_W-1:0]        lk_asid,
    output logic [ENTRIES-1:0]       match_vec,
    output logic [ENTRIES*PFN_W-1:0] pfn_flat,
    output logic [ENTRIES-1:0]       cach_vec
);

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              cach;
    } slot_t;

    slot_t slot_q [ENTRIES];
    slot_t slot_d [ENTRIES];

    // Next-state: one slot may be rewritten per cycle
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    slot_d[i].valid = wr_valid;
                    slot_d[i].vpn   = wr_vpn;
                    slot_d[i].asid  = wr_asid;
                    slot_d[i].pfn   = wr_pfn;
                    slot_d[i].cach  = wr_cacheable;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    // Parallel compare against every slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = slot_q[g].valid
                            && (slot_q[g].vpn  == lk_vpn)
                            && (slot_q[g].asid == lk_asid);
        assign pfn_flat[g*PFN_W +: PFN_W] = slot_q[g].pfn;
        assign cach_vec[g] = slot_q[g].cach;
    end

endmodule

// File: rtl/tlb_first_match.sv
module tlb_first_match #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any_match,
    output logic [IDX_W-1:0]   sel_idx
);

    // Scan from the top down so the lowest set bit is the last to win
    always_comb begin
        sel_idx   = '0;
        any_match = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_idx   = IDX_W'(i);
                any_match = 1'b1;
            end
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int ASID_W  = 6,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 64,
    localparam int VPN_W  = VA_W - PAGE_W,
    localparam int PA_W   = PFN_W + PAGE_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [PAGE_W-1:0] lk_offset,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_cacheable,
    input  logic              wr_valid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              rsp_cacheable,
    output logic [PA_W-1:0]   rsp_paddr
);

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            fault;
        logic            cach;
        logic [PA_W-1:0] paddr;
    } resp_t;

    resp_t resp_d, resp_q;

    seg_kind_e                seg_kind;
    logic [ENTRIES-1:0]       match_vec;
    logic [ENTRIES*PFN_W-1:0] pfn_flat;
    logic [ENTRIES-1:0]       cach_vec;
    logic                     any_match;
    logic [IDX_W-1:0]         sel_idx;
    logic [VPN_W-1:0]         lk_vpn;
    logic [PA_W-1:0]          phys_window_pa;

    assign lk_vpn         = lk_vaddr[VA_W-1:PAGE_W];
    assign lk_offset      = lk_vaddr[PAGE_W-1:0];
    assign phys_window_pa = PA_W'(lk_vaddr[VA_W-SEG_W-1:0]);

    tlb_seg_decode u_seg (
        .top_bits (lk_vaddr[VA_W-1:VA_W-SEG_W]),
        .kind     (seg_kind)
    );

    tlb_entry_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .PFN_W   (PFN_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_vpn       (wr_vpn),
        .wr_asid      (wr_asid),
        .wr_pfn       (wr_pfn),
        .wr_cacheable (wr_cacheable),
        .wr_valid     (wr_valid),
        .lk_vpn       (lk_vpn),
        .lk_asid      (lk_asid),
        .match_vec    (match_vec),
        .pfn_flat     (pfn_flat),
        .cach_vec     (cach_vec)
    );

    tlb_first_match #(
        .ENTRIES (ENTRIES)
    ) u_pick (
        .match_vec (match_vec),
        .any_match (any_match),
        .sel_idx   (sel_idx)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.valid = lk_valid;
        if (lk_valid) begin
            unique case (seg_kind)
                SEG_PHYS_C: begin
                    resp_d.hit   = 1'b1;
                    resp_d.cach  = 1'b1;
                    resp_d.paddr = phys_window_pa;
                end
                SEG_PHYS_UC: begin
                    resp_d.hit   = 1'b1;
                    resp_d.cach  = 1'b0;
                    resp_d.paddr = phys_window_pa;
                end
                default: begin
                    if (any_match) begin
                        resp_d.hit   = 1'b1;
                        resp_d.cach  = cach_vec[sel_idx];
                        resp_d.paddr = {pfn_flat[sel_idx*PFN_W +: PFN_W], lk_offset};
                    end else begin
                        resp_d.fault = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid     = resp_q.valid;
    assign rsp_hit       = resp_q.hit;
    assign rsp_fault     = resp_q.fault;
    assign rsp_cacheable = resp_q.cach;
    assign rsp_paddr     = resp_q.paddr;

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int PA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [PAGE_W-1:0] lk_offset,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic              rsp_cacheable,
    input logic [PA_W-1:0]   rsp_paddr
);

    localparam int TOP_W = 3;

    logic [PA_W-1:0] window_pa;
    assign window_pa = PA_W'(lk_vaddr[VA_W-TOP_W-1:0]);

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));

    a_r5_fault_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && !rsp_cacheable));

    a_r6_cached_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[VA_W-1 -: TOP_W] == 3'b100)
        |=> (rsp_hit && rsp_cacheable && rsp_paddr == $past(window_pa)));

    a_r7_uncached_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[VA_W-1 -: TOP_W] == 3'b101)
        |=> (rsp_hit && !rsp_cacheable && rsp_paddr == $past(window_pa)));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_vaddr[VA_W-1])
        |=> (!rsp_hit || rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

    a_r11_offset_now: assert property (@(posedge clk) disable iff (!rst_n)
        lk_offset == lk_vaddr[PAGE_W-1:0]);

endmodule

bind asid_tlb asid_tlb_checker #(
    .VA_W   (VA_W),
    .PAGE_W (PAGE_W),
    .PA_W   (PA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_vaddr      (lk_vaddr),
    .lk_offset     (lk_offset),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_fault     (rsp_fault),
    .rsp_cacheable (rsp_cacheable),
    .rsp_paddr     (rsp_paddr)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic [11:0] lk_offset;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_cacheable = 1'b0;
    logic        wr_valid = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_cacheable;
    logic [31:0] rsp_paddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_offset(lk_offset),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_pfn(wr_pfn), .wr_cacheable(wr_cacheable), .wr_valid(wr_valid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_cacheable(rsp_cacheable), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input logic [5:0] idx, input logic [19:0] vpn,
                               input logic [5:0] asid, input logic [19:0] pfn,
                               input logic cach, input logic vld);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid;
        wr_pfn = pfn; wr_cacheable = cach; wr_valid = vld;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup; results are stable at the following falling edge
    task automatic lookup(input logic [31:0] va, input logic [5:0] asid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] pa, input logic cach);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'd1);
        check({tag, " fault"}, 32'(rsp_fault), 32'd0);
        check({tag, " paddr"}, rsp_paddr, pa);
        check({tag, " cach"},  32'(rsp_cacheable), 32'(cach));
    endtask

    task automatic expect_fault(input string tag);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'd0);
        check({tag, " fault"}, 32'(rsp_fault), 32'd1);
        check({tag, " paddr"}, rsp_paddr, 32'd0);
        check({tag, " cach"},  32'(rsp_cacheable), 32'd0);
    endtask

    task automatic t_reset_state;
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        lookup(32'h0000_1234, 6'd0);
        expect_fault("R1 empty table user lookup");
        lookup(32'hC000_0000, 6'd0);
        expect_fault("R1 empty table kernel-virtual lookup");
    endtask

    task automatic t_phys_windows;
        lookup(32'h8ABC_D123, 6'd9);
        expect_hit("R6 cached window", 32'h0ABC_D123, 1'b1);
        lookup(32'hBFFF_F00F, 6'd9);
        expect_hit("R7 uncached window", 32'h1FFF_F00F, 1'b0);
    endtask

    task automatic t_user_hit_and_latency;
        write_entry(6'd5, 20'h00012, 6'd3, 20'hABCDE, 1'b1, 1'b1);
        lookup(32'h0001_2345, 6'd3);
        expect_hit("R3 user hit", 32'hABCD_E345, 1'b1);
        @(negedge clk);
        check("R2 no response without request", 32'(rsp_valid), 32'd0);
        check("R12 quiet when idle", 32'(rsp_hit | rsp_fault), 32'd0);
    endtask

    task automatic t_asid_mismatch;
        lookup(32'h0001_2345, 6'd4);
        expect_fault("R4 other address space");
    endtask

    task automatic t_kernel_virtual;
        write_entry(6'd63, 20'hC0001, 6'd3, 20'h12345, 1'b0, 1'b1);
        write_entry(6'd10, 20'hE0002, 6'd3, 20'h0F0F0, 1'b1, 1'b1);
        lookup(32'hC000_1ABC, 6'd3);
        expect_hit("R8 kernel virtual 110", 32'h1234_5ABC, 1'b0);
        lookup(32'hE000_2777, 6'd3);
        expect_hit("R8 kernel virtual 111", 32'h0F0F_0777, 1'b1);
        lookup(32'h4001_2345, 6'd3);
        expect_fault("R8 user 010 translated, no entry");
    endtask

    task automatic t_invalidate;
        write_entry(6'd5, 20'h00012, 6'd3, 20'hABCDE, 1'b1, 1'b0);
        lookup(32'h0001_2345, 6'd3);
        expect_fault("R5 invalidated entry");
    endtask

    task automatic t_multi_match;
        write_entry(6'd20, 20'h00777, 6'd1, 20'h22222, 1'b0, 1'b1);
        write_entry(6'd7,  20'h00777, 6'd1, 20'h11111, 1'b1, 1'b1);
        lookup(32'h0077_7010, 6'd1);
        expect_hit("R9 lowest index wins", 32'h1111_1010, 1'b1);
        write_entry(6'd7, 20'h00777, 6'd1, 20'h11111, 1'b1, 1'b0);
        lookup(32'h0077_7010, 6'd1);
        expect_hit("R9 next index after invalidate", 32'h2222_2010, 1'b0);
    endtask

    task automatic t_write_visibility;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd30; wr_vpn = 20'h00333; wr_asid = 6'd2;
        wr_pfn = 20'h33333; wr_cacheable = 1'b1; wr_valid = 1'b1;
        lk_valid = 1'b1; lk_vaddr = 32'h0033_3ABC; lk_asid = 6'd2;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        expect_fault("R10 same-cycle write not seen");
        lookup(32'h0033_3ABC, 6'd2);
        expect_hit("R10 seen on next lookup", 32'h3333_3ABC, 1'b1);
    endtask

    task automatic t_offset_passthrough;
        @(negedge clk);
        lk_vaddr = 32'h1234_5DEF;
        #1;
        check("R11 offset same cycle", 32'(lk_offset), 32'h0000_0DEF);
        lk_vaddr = 32'hFFFF_F001;
        #1;
        check("R11 offset follows input", 32'(lk_offset), 32'h0000_0001);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_phys_windows();
        t_user_hit_and_latency();
        t_asid_mismatch();
        t_kernel_virtual();
        t_invalidate();
        t_multi_match();
        t_write_visibility();
        t_offset_passthrough();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule